// File: doc/BRIEF.md
# CPU Status Flag Register Unit

This block holds the processor's 8-bit status word and the logic that updates it. The word carries the global interrupt enable, a single-bit copy store used by bit-move operations, and six arithmetic flags (half carry, sign, overflow, negative, zero, carry). The ALU computes candidate flag values and presents them with a per-flag update mask. The unit keeps only the masked flags and derives the sign flag from the new negative and overflow values.

Software reaches the register through two bus ports. The full data-space port decodes address 0x5F. The short I/O-space port decodes 0x3F, which is the same address minus 0x20. Reads on either port are combinational. The control path drives single-cycle strobes for interrupt entry, interrupt return, and explicit set or clear of the interrupt enable. It also drives a bit-store/bit-load path that moves one selected operand bit into or out of the copy flag. The interrupt enable gates a vector of per-source request and enable pairs before they reach arbitration.

Top module: `sreg_unit`

## Requirements
- R1: While rst_ni is low the register is 0x00. Bit order from bit 7 down to bit 0 is I, T, H, S, V, N, Z, C, and every bit is readable and writable.
- R2: The data port hits only at address 0x5F. A hit returns the register on dbus_rdata_o and, with dbus_we_i, loads dbus_wdata_i on the next rising edge. A miss returns 0 and a write to a missed address leaves the register unchanged.
- R3: The I/O port hits only at 6-bit address 0x3F and otherwise acts like the data port. When both ports write in the same cycle, the data port value is stored.
- R4: With alu_upd_i high, each flag whose alu_mask_i bit is set takes its candidate from alu_flags_i, and every other bit keeps its value. Mask bits are 0=C, 1=Z, 2=N, 3=V, 4=S, 5=H. Candidate bits are 0=C, 1=Z, 2=N, 3=V, 4=H. I and T never change through this path.
- R5: On an ALU update whose mask sets N, V or S, the stored S becomes the XOR of the new N and V values.
- R6: A bus write hit takes priority over a same-cycle ALU update and bit-store. All eight bits are stored as given, including an S that differs from N XOR V.
- R7: sei_i and reti_i set I, and cli_i clears it. cli_i wins over sei_i and reti_i. All three override the I bit of a same-cycle bus write.
- R8: irq_take_i clears I on the next edge and overrides every other source of I, including a bus write in the same cycle.
- R9: bst_i copies bit_opnd_i[bit_sel_i] into T when no bus write hits.
- R10: bld_data_o equals bit_opnd_i with the bit at bit_sel_i replaced by T, combinationally.
- R11: gie_o equals I. irq_pend_o equals irq_req_i AND irq_en_i when I is 1, and is all zeros when I is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbus_addr_i | input | 8 | Data-space address |
| dbus_we_i | input | 1 | Data-space write strobe |
| dbus_wdata_i | input | 8 | Data-space write data |
| dbus_rdata_o | output | 8 | Data-space read data, 0 on miss |
| dbus_hit_o | output | 1 | Data-space address matches |
| iobus_addr_i | input | 6 | I/O-space address |
| iobus_we_i | input | 1 | I/O-space write strobe |
| iobus_wdata_i | input | 8 | I/O-space write data |
| iobus_rdata_o | output | 8 | I/O-space read data, 0 on miss |
| iobus_hit_o | output | 1 | I/O-space address matches |
| alu_upd_i | input | 1 | Apply ALU flag candidates |
| alu_mask_i | input | 6 | Per-flag update mask |
| alu_flags_i | input | 5 | Candidate flag values |
| sei_i | input | 1 | Set interrupt enable |
| cli_i | input | 1 | Clear interrupt enable |
| reti_i | input | 1 | Return from interrupt |
| irq_take_i | input | 1 | Interrupt entry |
| bst_i | input | 1 | Copy selected operand bit into T |
| bit_sel_i | input | 3 | Bit index for store/load |
| bit_opnd_i | input | 8 | Operand for bit store/load |
| bld_data_o | output | 8 | Operand with selected bit replaced by T |
| irq_req_i | input | 4 | Per-source interrupt requests |
| irq_en_i | input | 4 | Per-source interrupt enables |
| irq_pend_o | output | 4 | Gated interrupt requests |
| gie_o | output | 1 | Global interrupt enable |
| sreg_o | output | 8 | Current register value |

## Verification
The bench drives the collision cases. These are a bus write landing together with interrupt entry, a bus write together with an ALU update, both ports writing at once, and sei together with cli. A wrong priority order would leave I set after an interrupt, let ALU flags overwrite a write, or store the I/O value. A raw write of S=1 with N=V=0 must be stored as given; a design that forces the sign relation on every path would store 0 instead. Random ALU updates whose mask covers S but not N or V check that S is rebuilt from the held N and V. Writes one address off either match value check that a loose decoder fails.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned SREG_W = 8;

  // status word bit positions
  localparam int unsigned BIT_C = 0;
  localparam int unsigned BIT_Z = 1;
  localparam int unsigned BIT_N = 2;
  localparam int unsigned BIT_V = 3;
  localparam int unsigned BIT_S = 4;
  localparam int unsigned BIT_H = 5;
  localparam int unsigned BIT_T = 6;
  localparam int unsigned BIT_I = 7;

  // ALU update mask positions
  localparam int unsigned MSK_C = 0;
  localparam int unsigned MSK_Z = 1;
  localparam int unsigned MSK_N = 2;
  localparam int unsigned MSK_V = 3;
  localparam int unsigned MSK_S = 4;
  localparam int unsigned MSK_H = 5;
  localparam int unsigned ALU_MASK_W = 6;

  // ALU candidate positions
  localparam int unsigned CND_C = 0;
  localparam int unsigned CND_Z = 1;
  localparam int unsigned CND_N = 2;
  localparam int unsigned CND_V = 3;
  localparam int unsigned CND_H = 4;
  localparam int unsigned ALU_CND_W = 5;

  typedef logic [SREG_W-1:0] sreg_t;
endpackage

// File: rtl/sreg_bus_port.sv
module sreg_bus_port
  import sreg_pkg::*;
#(
  parameter int unsigned     AW    = 8,
  parameter logic [AW-1:0]   MATCH = '0
) (
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  sreg_t         q_i,
  output logic          hit_o,
  output logic          wr_o,
  output sreg_t         rdata_o
);
  assign hit_o   = (addr_i == MATCH);
  assign wr_o    = hit_o & we_i;
  assign rdata_o = hit_o ? q_i : '0;
endmodule

// File: rtl/sreg_bitcopy.sv
module sreg_bitcopy #(
  parameter int unsigned W  = 8,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [SW-1:0] sel_i,
  input  logic [W-1:0]  opnd_i,
  input  logic          t_i,
  output logic          bst_bit_o,
  output logic [W-1:0]  bld_data_o
);
  assign bst_bit_o = opnd_i[sel_i];

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign bld_data_o[g] = (sel_i == SW'(g)) ? t_i : opnd_i[g];
  end
endmodule

// File: rtl/sreg_irq_gate.sv
module sreg_irq_gate #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gie_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign pend_o[g] = gie_i & req_i[g] & en_i[g];
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      assert_gate_R11: assert (gie_i || pend_o == '0)
        else $error("pending request while globally disabled");
    end
  end
endmodule

// File: rtl/sreg_next.sv
module sreg_next
  import sreg_pkg::*;
(
  input  sreg_t                 q_i,
  input  logic                  d_wr_i,
  input  sreg_t                 d_wdata_i,
  input  logic                  io_wr_i,
  input  sreg_t                 io_wdata_i,
  input  logic                  alu_upd_i,
  input  logic [ALU_MASK_W-1:0] alu_mask_i,
  input  logic [ALU_CND_W-1:0]  alu_flags_i,
  input  logic                  bst_i,
  input  logic                  bst_bit_i,
  input  logic                  sei_i,
  input  logic                  cli_i,
  input  logic                  reti_i,
  input  logic                  irq_take_i,
  output sreg_t                 d_o
);
  sreg_t alu_v;
  sreg_t base_v;

  // ALU / bit-store path
  always_comb begin
    alu_v = q_i;
    if (alu_upd_i) begin
      if (alu_mask_i[MSK_C]) alu_v[BIT_C] = alu_flags_i[CND_C];
      if (alu_mask_i[MSK_Z]) alu_v[BIT_Z] = alu_flags_i[CND_Z];
      if (alu_mask_i[MSK_N]) alu_v[BIT_N] = alu_flags_i[CND_N];
      if (alu_mask_i[MSK_V]) alu_v[BIT_V] = alu_flags_i[CND_V];
      if (alu_mask_i[MSK_H]) alu_v[BIT_H] = alu_flags_i[CND_H];
      if (alu_mask_i[MSK_N] | alu_mask_i[MSK_V] | alu_mask_i[MSK_S])
        alu_v[BIT_S] = alu_v[BIT_N] ^ alu_v[BIT_V];
    end
    if (bst_i) alu_v[BIT_T] = bst_bit_i;
  end

  // bus writes override, data port over I/O port
  always_comb begin
    base_v = alu_v;
    if (io_wr_i) base_v = io_wdata_i;
    if (d_wr_i)  base_v = d_wdata_i;
  end

  // interrupt enable side effects, irq entry last
  always_comb begin
    d_o = base_v;
    if (sei_i | reti_i) d_o[BIT_I] = 1'b1;
    if (cli_i)          d_o[BIT_I] = 1'b0;
    if (irq_take_i)     d_o[BIT_I] = 1'b0;
  end
endmodule

// File: rtl/sreg_unit.sv
module sreg_unit
  import sreg_pkg::*;
#(
  parameter int unsigned  IRQ_N     = 4,
  parameter int unsigned  DAW       = 8,
  parameter int unsigned  IOAW      = 6,
  parameter int unsigned  DATA_ADDR = 'h5F,
  parameter int unsigned  IO_OFFSET = 'h20,
  localparam int unsigned IO_ADDR   = DATA_ADDR - IO_OFFSET,
  localparam int unsigned SELW      = $clog2(SREG_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DAW-1:0]        dbus_addr_i,
  input  logic                  dbus_we_i,
  input  logic [SREG_W-1:0]     dbus_wdata_i,
  output logic [SREG_W-1:0]     dbus_rdata_o,
  output logic                  dbus_hit_o,
  input  logic [IOAW-1:0]       iobus_addr_i,
  input  logic                  iobus_we_i,
  input  logic [SREG_W-1:0]     iobus_wdata_i,
  output logic [SREG_W-1:0]     iobus_rdata_o,
  output logic                  iobus_hit_o,
  input  logic                  alu_upd_i,
  input  logic [ALU_MASK_W-1:0] alu_mask_i,
  input  logic [ALU_CND_W-1:0]  alu_flags_i,
  input  logic                  sei_i,
  input  logic                  cli_i,
  input  logic                  reti_i,
  input  logic                  irq_take_i,
  input  logic                  bst_i,
  input  logic [SELW-1:0]       bit_sel_i,
  input  logic [SREG_W-1:0]     bit_opnd_i,
  output logic [SREG_W-1:0]     bld_data_o,
  input  logic [IRQ_N-1:0]      irq_req_i,
  input  logic [IRQ_N-1:0]      irq_en_i,
  output logic [IRQ_N-1:0]      irq_pend_o,
  output logic                  gie_o,
  output logic [SREG_W-1:0]     sreg_o
);
  sreg_t sreg_q, sreg_d;
  logic  d_wr, io_wr, bst_bit;

  sreg_bus_port #(.AW(DAW), .MATCH(DAW'(DATA_ADDR))) u_dport (
    .addr_i (dbus_addr_i), .we_i (dbus_we_i), .q_i (sreg_q),
    .hit_o  (dbus_hit_o),  .wr_o (d_wr),      .rdata_o (dbus_rdata_o)
  );

  sreg_bus_port #(.AW(IOAW), .MATCH(IOAW'(IO_ADDR))) u_ioport (
    .addr_i (iobus_addr_i), .we_i (iobus_we_i), .q_i (sreg_q),
    .hit_o  (iobus_hit_o),  .wr_o (io_wr),      .rdata_o (iobus_rdata_o)
  );

  sreg_bitcopy #(.W(SREG_W)) u_bitcopy (
    .sel_i (bit_sel_i), .opnd_i (bit_opnd_i), .t_i (sreg_q[BIT_T]),
    .bst_bit_o (bst_bit), .bld_data_o (bld_data_o)
  );

  sreg_next u_next (
    .q_i (sreg_q),
    .d_wr_i (d_wr), .d_wdata_i (dbus_wdata_i),
    .io_wr_i (io_wr), .io_wdata_i (iobus_wdata_i),
    .alu_upd_i (alu_upd_i), .alu_mask_i (alu_mask_i), .alu_flags_i (alu_flags_i),
    .bst_i (bst_i), .bst_bit_i (bst_bit),
    .sei_i (sei_i), .cli_i (cli_i), .reti_i (reti_i), .irq_take_i (irq_take_i),
    .d_o (sreg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= '0;
    else         sreg_q <= sreg_d;
  end

  assign gie_o  = sreg_q[BIT_I];
  assign sreg_o = sreg_q;

  sreg_irq_gate #(.N(IRQ_N)) u_irq_gate (
    .clk_i (clk_i), .rst_ni (rst_ni), .gie_i (sreg_q[BIT_I]),
    .req_i (irq_req_i), .en_i (irq_en_i), .pend_o (irq_pend_o)
  );

  // bits an ALU-only update must not touch
  logic  i_ops, any_wr, sign_upd;
  sreg_t keep_m;
  assign i_ops    = sei_i | cli_i | reti_i | irq_take_i;
  assign any_wr   = d_wr | io_wr;
  assign sign_upd = alu_mask_i[MSK_N] | alu_mask_i[MSK_V] | alu_mask_i[MSK_S];
  always_comb begin
    keep_m        = '1;
    keep_m[BIT_C] = ~alu_mask_i[MSK_C];
    keep_m[BIT_Z] = ~alu_mask_i[MSK_Z];
    keep_m[BIT_N] = ~alu_mask_i[MSK_N];
    keep_m[BIT_V] = ~alu_mask_i[MSK_V];
    keep_m[BIT_H] = ~alu_mask_i[MSK_H];
    keep_m[BIT_S] = ~sign_upd;
  end

  assert_irq_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i |=> !gie_o);

  assert_cli_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cli_i |=> !gie_o);

  assert_sei_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sei_i | reti_i) && !cli_i && !irq_take_i) |=> gie_o);

  assert_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_upd_i && sign_upd && !any_wr) |=> (sreg_o[BIT_S] == (sreg_o[BIT_N] ^ sreg_o[BIT_V])));

  assert_bus_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbus_hit_o && dbus_we_i && !i_ops) |=> (sreg_o == $past(dbus_wdata_i)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_upd_i && !any_wr && !bst_i && !i_ops) |=> ((sreg_o & $past(keep_m)) == ($past(sreg_o) & $past(keep_m))));
endmodule

// File: tb/tb_sreg_unit.sv
`timescale 1ns/1ps
module tb_sreg_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] dbus_addr_i, dbus_wdata_i, dbus_rdata_o;
  logic       dbus_we_i, dbus_hit_o;
  logic [5:0] iobus_addr_i;
  logic       iobus_we_i, iobus_hit_o;
  logic [7:0] iobus_wdata_i, iobus_rdata_o;
  logic       alu_upd_i;
  logic [5:0] alu_mask_i;
  logic [4:0] alu_flags_i;
  logic       sei_i, cli_i, reti_i, irq_take_i, bst_i;
  logic [2:0] bit_sel_i;
  logic [7:0] bit_opnd_i, bld_data_o;
  logic [3:0] irq_req_i, irq_en_i, irq_pend_o;
  logic       gie_o;
  logic [7:0] sreg_o;

  int checks = 0, fails = 0;
  logic [7:0] model;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  sreg_unit dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_next(input logic [7:0] q);
    logic [7:0] n = q;
    if (alu_upd_i) begin
      if (alu_mask_i[0]) n[0] = alu_flags_i[0];
      if (alu_mask_i[1]) n[1] = alu_flags_i[1];
      if (alu_mask_i[2]) n[2] = alu_flags_i[2];
      if (alu_mask_i[3]) n[3] = alu_flags_i[3];
      if (alu_mask_i[5]) n[5] = alu_flags_i[4];
      if (alu_mask_i[2] | alu_mask_i[3] | alu_mask_i[4]) n[4] = n[2] ^ n[3];
    end
    if (bst_i) n[6] = bit_opnd_i[bit_sel_i];
    if (iobus_we_i && iobus_addr_i == 6'h3F) n = iobus_wdata_i;
    if (dbus_we_i && dbus_addr_i == 8'h5F) n = dbus_wdata_i;
    if (sei_i | reti_i) n[7] = 1'b1;
    if (cli_i) n[7] = 1'b0;
    if (irq_take_i) n[7] = 1'b0;
    return n;
  endfunction

  function automatic string auto_tag();
    if (irq_take_i) return "R8";
    if (sei_i | cli_i | reti_i) return "R7";
    if (dbus_we_i && dbus_addr_i == 8'h5F) return "R6";
    if (iobus_we_i && iobus_addr_i == 6'h3F) return "R3";
    if (alu_upd_i) return (alu_mask_i[2] | alu_mask_i[3] | alu_mask_i[4]) ? "R5" : "R4";
    if (bst_i) return "R9";
    return "R2";
  endfunction

  task automatic idle();
    dbus_addr_i = 8'h00; dbus_we_i = 0; dbus_wdata_i = 8'h00;
    iobus_addr_i = 6'h00; iobus_we_i = 0; iobus_wdata_i = 8'h00;
    alu_upd_i = 0; alu_mask_i = '0; alu_flags_i = '0;
    sei_i = 0; cli_i = 0; reti_i = 0; irq_take_i = 0; bst_i = 0;
    bit_sel_i = '0; bit_opnd_i = '0; irq_req_i = '0; irq_en_i = '0;
  endtask

  // inputs are set; check comb outputs, clock once, check state at negedge
  task automatic cycle(input string tag);
    string t;
    logic [7:0] bld_exp;
    #1;
    check("R2 rdata", dbus_rdata_o, (dbus_addr_i == 8'h5F) ? model : 8'h00);
    check("R3 rdata", iobus_rdata_o, (iobus_addr_i == 6'h3F) ? model : 8'h00);
    bld_exp = bit_opnd_i;
    bld_exp[bit_sel_i] = model[6];
    check("R10 bld", bld_data_o, bld_exp);
    check("R11 gie", gie_o, model[7]);
    check("R11 pend", irq_pend_o, model[7] ? (irq_req_i & irq_en_i) : 4'h0);
    t = (tag == "") ? auto_tag() : tag;
    model = model_next(model);
    @(negedge clk_i);
    check(t, sreg_o, model);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    check("R1 reset", sreg_o, 8'h00);
    rst_ni = 1;
    model = 8'h00;
    @(negedge clk_i);
    check("R1 hold", sreg_o, 8'h00);

    // R6: raw write, S inconsistent with N^V
    idle(); dbus_addr_i = 8'h5F; dbus_we_i = 1; dbus_wdata_i = 8'h10;
    alu_upd_i = 1; alu_mask_i = 6'h3F; alu_flags_i = 5'h1F;
    cycle("R6");
    // R2: neighbouring address misses
    idle(); dbus_addr_i = 8'h5E; dbus_we_i = 1; dbus_wdata_i = 8'hFF;
    cycle("R2");
    idle(); dbus_addr_i = 8'h3F; dbus_we_i = 1; dbus_wdata_i = 8'hFF;
    cycle("R2");
    // R3: I/O write alone, then both ports together
    idle(); iobus_addr_i = 6'h3F; iobus_we_i = 1; iobus_wdata_i = 8'h5A;
    cycle("R3");
    idle(); iobus_addr_i = 6'h3F; iobus_we_i = 1; iobus_wdata_i = 8'hA5;
    dbus_addr_i = 8'h5F; dbus_we_i = 1; dbus_wdata_i = 8'h3C;
    cycle("R3");
    // R7: sei and cli together
    idle(); sei_i = 1; cli_i = 1;
    cycle("R7");
    idle(); reti_i = 1;
    cycle("R7");
    // R8: bus write of all ones with interrupt entry
    idle(); dbus_addr_i = 8'h5F; dbus_we_i = 1; dbus_wdata_i = 8'hFF; irq_take_i = 1;
    cycle("R8");
    // R5: mask S only, N and V held
    idle(); alu_upd_i = 1; alu_mask_i = 6'h10; alu_flags_i = 5'h00;
    cycle("R5");
    // R4: only carry masked
    idle(); alu_upd_i = 1; alu_mask_i = 6'h01; alu_flags_i = 5'h00;
    cycle("R4");
    // R9: bit-store of bit 5
    idle(); bst_i = 1; bit_sel_i = 3'd5; bit_opnd_i = 8'h20;
    cycle("R9");
    idle(); bit_sel_i = 3'd0; bit_opnd_i = 8'h00; sei_i = 1;
    cycle("R10");

    for (int i = 0; i < 3000; i++) begin
      idle();
      dbus_addr_i   = ($urandom % 3 == 0) ? 8'h5F : 8'($urandom);
      dbus_we_i     = ($urandom % 4 == 0);
      dbus_wdata_i  = 8'($urandom);
      iobus_addr_i  = ($urandom % 3 == 0) ? 6'h3F : 6'($urandom);
      iobus_we_i    = ($urandom % 4 == 0);
      iobus_wdata_i = 8'($urandom);
      alu_upd_i     = ($urandom % 2 == 0);
      alu_mask_i    = 6'($urandom);
      alu_flags_i   = 5'($urandom);
      sei_i         = ($urandom % 10 == 0);
      cli_i         = ($urandom % 10 == 0);
      reti_i        = ($urandom % 10 == 0);
      irq_take_i    = ($urandom % 10 == 0);
      bst_i         = ($urandom % 4 == 0);
      bit_sel_i     = 3'($urandom);
      bit_opnd_i    = 8'($urandom);
      irq_req_i     = 4'($urandom);
      irq_en_i      = 4'($urandom);
      cycle("");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule